// File: doc/BRIEF.md
# Byte-per-Clock Stream Cipher Keystream Generator

This block turns a byte permutation table into an RC4 keystream at one byte per clock. The table sits in a register bank inside the block. The key scheduler fills the bank through a simple write port while the generator is idle. It then raises the enable and supplies a byte count. The generator keeps an index counter and an accumulator. On every step it swaps two table entries and looks up the output byte in the table as it stands after the swap. Each byte leaves the block on a registered output together with a one-cycle valid strobe. The consumer XORs the bytes with its data.

A run takes one setup clock and then one clock per byte. A consumer that cannot take a byte pulls the ready input low. That freezes the generator for the cycle, with no swap and no byte, so nothing is dropped. When the count has been delivered, the block holds until the enable falls. Raising the enable again starts a fresh run on whatever table contents the last run left behind.

Top module: `rc4ks_top`

## Requirements
- R1: After reset, `ks_valid` is low and the table holds the identity permutation (entry k holds k), so a run with no loads yields the keystream of the identity table.
- R2: While the generator is idle (`ks_en` low, no run in progress), a cycle with `ld_we` high writes `ld_data` into table entry `ld_addr`.
- R3: The clock edge that sees `ks_en` rise in the idle state sets the index counter to 1 and the accumulator to 0. The stream then matches the standard cipher: the table built from key bytes 0x4B 0x65 0x79 gives EB 9F 77 81 B7 34 CA 72 A7 19.
- R4: On each step the accumulator becomes (accumulator + S[index]) mod 2^W, using the current index. The entries at the index and at the new accumulator are then exchanged, and the index goes up by one for the next step.
- R5: The output byte is S[(S[index] + S[acc]) mod 2^W], read from the table after the exchange. This holds even when that address equals the index or the accumulator.
- R6: For a count n ≥ 1, `ks_valid` is high in exactly n cycles. With `out_rdy` held high the first byte appears one clock after the start edge and the last byte n clocks after it, n+1 clocks in total. No further byte appears while `ks_en` stays high.
- R7: The index counter wraps from 2^W−1 to 0 and generation continues correctly across the wrap.
- R8: A clock edge with `out_rdy` low and a run in progress changes nothing: no swap, no index or accumulator update, and no strobe in the following cycle. The byte sequence after the stall is unchanged.
- R9: A count of 0 yields no strobe at all.
- R10: `ld_we` is ignored while a run is in progress or finished, and the table stays untouched.
- R11: Dropping `ks_en` returns the block to idle. A later rising enable starts a new run from index 1 and accumulator 0 on the current table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Table write strobe, honoured only while idle |
| ld_addr | input | W | Table entry to write |
| ld_data | input | W | Value to write |
| ks_en | input | 1 | Enable from the scheduler's done flag; rising in idle starts a run |
| ks_len | input | CNT_W | Number of bytes to produce, sampled at the start edge |
| out_rdy | input | 1 | Consumer ready; low stalls the generator for that edge |
| ks_valid | output | 1 | One-cycle strobe per keystream byte |
| ks_byte | output | W | Keystream byte, valid with `ks_valid` |

## Verification
The bench builds the block with W = 8, a full 256-entry table, and CNT_W = 12. At these values a published cipher test vector can be compared byte for byte, and a 300-byte run is long enough to cross the index wrap. Small permutations built on purpose make the lookup address coincide with the index and then with the accumulator. Those two cases separate a lookup that sees the table after the exchange from one that sees it before. A ready pattern that drops one cycle in three, together with load attempts during a run, covers the freeze and ignore rules.

// File: rtl/rc4ks_pkg.sv
// Package: shared types for the keystream generator.
// Assumes nothing beyond the IEEE 1800-2017 language.
package rc4ks_pkg;
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_RUN  = 2'd1,
        KS_DONE = 2'd2
    } ks_state_e;
endpackage

// File: rtl/rc4ks_sbox.sv
// Permutation table of 2^W entries of W bits.
// Provides two combinational read ports (a, b), an exchange of entries a and b
// on swap_en, a load port, and a lookup port that returns the entry as it will
// read after this cycle's exchange.
// Assumes the caller never raises swap_en and ld_we together.
module rc4ks_sbox #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_we,
    input  logic [W-1:0] ld_addr,
    input  logic [W-1:0] ld_data,
    input  logic [W-1:0] idx_a,
    input  logic [W-1:0] idx_b,
    input  logic         swap_en,
    input  logic [W-1:0] idx_t,
    output logic [W-1:0] rd_a,
    output logic [W-1:0] rd_b,
    output logic [W-1:0] rd_t_post
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] cells [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cell
            logic [W-1:0] cell_q;
            // Purpose: hold one entry; reset to identity, exchange, or load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q <= W'(g);
                end else if (swap_en && (idx_a == W'(g))) begin
                    cell_q <= rd_b;
                end else if (swap_en && (idx_b == W'(g))) begin
                    cell_q <= rd_a;
                end else if (ld_we && (ld_addr == W'(g))) begin
                    cell_q <= ld_data;
                end
            end
            assign cells[g] = cell_q;
        end
    endgenerate

    assign rd_a = cells[idx_a];
    assign rd_b = cells[idx_b];

    // Purpose: lookup that sees the table after the pending exchange.
    always_comb begin
        if (idx_t == idx_a) begin
            rd_t_post = rd_b;
        end else if (idx_t == idx_b) begin
            rd_t_post = rd_a;
        end else begin
            rd_t_post = cells[idx_t];
        end
    end

    // R10: a load never coincides with an exchange
    p_no_load_in_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(swap_en && ld_we));

    // R4: after an exchange, entry a holds what entry b held
    p_swap_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> (cells[$past(idx_a)] == $past(rd_b)));

endmodule

// File: rtl/rc4ks_ctrl.sv
// Sequencer for the keystream generator: run state, index counter, accumulator
// and remaining-byte count. Issues one step per clock while enabled and the
// consumer is ready.
// Assumes ks_len is stable at the start edge; s_i is the table entry at idx_i.
module rc4ks_ctrl
    import rc4ks_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ks_en,
    input  logic [CNT_W-1:0] ks_len,
    input  logic             out_rdy,
    input  logic [W-1:0]     s_i,
    output logic [W-1:0]     idx_i,
    output logic [W-1:0]     idx_j,
    output logic             step,
    output logic             load_ok
);
    ks_state_e        st_q;
    logic [W-1:0]     i_q;
    logic [W-1:0]     j_q;
    logic [CNT_W-1:0] left_q;

    assign idx_i   = i_q;
    assign idx_j   = j_q + s_i;
    assign step    = (st_q == KS_RUN) && ks_en && out_rdy;
    assign load_ok = (st_q == KS_IDLE) && !ks_en;

    // Purpose: advance the run state, the index, the accumulator and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= KS_IDLE;
            i_q    <= '0;
            j_q    <= '0;
            left_q <= '0;
        end else begin
            case (st_q)
                KS_IDLE: begin
                    if (ks_en) begin
                        i_q    <= W'(1);
                        j_q    <= '0;
                        left_q <= ks_len;
                        st_q   <= (ks_len == '0) ? KS_DONE : KS_RUN;
                    end
                end
                KS_RUN: begin
                    if (!ks_en) begin
                        st_q <= KS_IDLE;
                    end else if (out_rdy) begin
                        i_q    <= i_q + W'(1);
                        j_q    <= idx_j;
                        left_q <= left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            st_q <= KS_DONE;
                        end
                    end
                end
                KS_DONE: begin
                    if (!ks_en) begin
                        st_q <= KS_IDLE;
                    end
                end
                default: st_q <= KS_IDLE;
            endcase
        end
    end

    // R3/R11: a start leaves index 1 and accumulator 0
    p_start_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == KS_IDLE && ks_en) |=> (i_q == W'(1) && j_q == '0));

    // R7: each step advances the index by one, modulo the table size
    p_index_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (i_q == $past(i_q) + W'(1)));

    // R8: a stalled run keeps index and accumulator
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == KS_RUN && ks_en && !out_rdy) |=> ($stable(i_q) && $stable(j_q)));

    // R6: the last step ends the run
    p_last_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && left_q == CNT_W'(1)) |=> (st_q == KS_DONE));

    // R9: a zero count never enters the running state
    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == KS_IDLE && ks_en && ks_len == '0) |=> (st_q == KS_DONE));

endmodule

// File: rtl/rc4ks_top.sv
// Keystream generator top: ties the sequencer to the permutation table, forms
// the lookup address from the exchanged pair and registers the output byte.
// Assumes the table has been loaded by the scheduler before ks_en rises.
module rc4ks_top #(
    parameter int W     = 8,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [W-1:0]     ld_addr,
    input  logic [W-1:0]     ld_data,
    input  logic             ks_en,
    input  logic [CNT_W-1:0] ks_len,
    input  logic             out_rdy,
    output logic             ks_valid,
    output logic [W-1:0]     ks_byte
);
    logic [W-1:0] idx_i;
    logic [W-1:0] idx_j;
    logic [W-1:0] s_i;
    logic [W-1:0] s_j;
    logic [W-1:0] idx_t;
    logic [W-1:0] z_post;
    logic         step;
    logic         load_ok;

    rc4ks_ctrl #(.W(W), .CNT_W(CNT_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ks_en   (ks_en),
        .ks_len  (ks_len),
        .out_rdy (out_rdy),
        .s_i     (s_i),
        .idx_i   (idx_i),
        .idx_j   (idx_j),
        .step    (step),
        .load_ok (load_ok)
    );

    // The sum of the pair is the same before and after the exchange.
    assign idx_t = s_i + s_j;

    rc4ks_sbox #(.W(W)) sbox_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_we     (ld_we && load_ok),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .idx_a     (idx_i),
        .idx_b     (idx_j),
        .swap_en   (step),
        .idx_t     (idx_t),
        .rd_a      (s_i),
        .rd_b      (s_j),
        .rd_t_post (z_post)
    );

    // Purpose: register the keystream byte and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_valid <= 1'b0;
            ks_byte  <= '0;
        end else begin
            ks_valid <= step;
            if (step) begin
                ks_byte <= z_post;
            end
        end
    end

    // R8/R11: a byte only follows an enabled, ready edge
    p_valid_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> ($past(ks_en) && $past(out_rdy)));

    // R6: the strobe is a single-bit, well-defined signal
    p_valid_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(ks_valid));

endmodule

// File: tb/rc4ks_top_tb_top.sv
`timescale 1ns/1ps
module rc4ks_top_tb_top;
    localparam int W  = 8;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_we;
    logic [W-1:0]  ld_addr;
    logic [W-1:0]  ld_data;
    logic          ks_en;
    logic [CW-1:0] ks_len;
    logic          out_rdy;
    logic          ks_valid;
    logic [W-1:0]  ks_byte;

    int n_checks = 0;
    int n_err    = 0;

    logic [7:0] m [256];
    int mi;
    int mj;
    logic [7:0] cap [16];

    always #2 clk = ~clk;

    rc4ks_top #(.W(W), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .ks_en(ks_en), .ks_len(ks_len), .out_rdy(out_rdy),
        .ks_valid(ks_valid), .ks_byte(ks_byte)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_next();
        logic [7:0] tmp;
        int t;
        mi = (mi + 1) % 256;
        mj = (mj + int'(m[mi])) % 256;
        tmp   = m[mi];
        m[mi] = m[mj];
        m[mj] = tmp;
        t = (int'(m[mi]) + int'(m[mj])) % 256;
        return int'(m[t]);
    endfunction

    function automatic void model_swap(input int a, input int b);
        logic [7:0] tmp;
        tmp  = m[a];
        m[a] = m[b];
        m[b] = tmp;
    endfunction

    function automatic void model_identity();
        for (int k = 0; k < 256; k++) m[k] = 8'(k);
    endfunction

    function automatic void model_ksa(input logic [7:0] k0, input logic [7:0] k1,
                                      input logic [7:0] k2, input int klen);
        int j;
        logic [7:0] kb;
        model_identity();
        j = 0;
        for (int k = 0; k < 256; k++) begin
            case (k % klen)
                0: kb = k0;
                1: kb = k1;
                default: kb = k2;
            endcase
            j = (j + int'(m[k]) + int'(kb)) % 256;
            model_swap(k, j);
        end
    endfunction

    task automatic load_table();
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_addr = 8'(k);
            ld_data = m[k];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // mode 0: ready high; mode 1: ready low one cycle in three; mode 2: loads during run
    task automatic run_stream(input int n, input int mode, input string req, output int last_c);
        int got;
        int z;
        bit rdy_prev;
        mi = 0;
        mj = 0;
        got = 0;
        last_c = -1;
        @(negedge clk);
        ks_len  = CW'(n);
        ks_en   = 1'b1;
        out_rdy = 1'b1;
        rdy_prev = 1'b1;
        for (int c = 1; c <= n * 3 + 12; c++) begin
            @(negedge clk);
            if (c == 1) chk(!ks_valid, "R6 start clock", int'(ks_valid), 0);
            if (c >= 2 && !rdy_prev) chk(!ks_valid, "R8 stall", int'(ks_valid), 0);
            if (ks_valid) begin
                z = model_next();
                chk(int'(ks_byte) == z, req, int'(ks_byte), z);
                if (got < 16) cap[got] = ks_byte;
                got++;
                last_c = c;
            end
            out_rdy  = (mode == 1) ? ((c % 3) != 0) : 1'b1;
            rdy_prev = out_rdy;
            if (mode == 2) begin
                ld_we   = 1'b1;
                ld_addr = 8'((c * 37) % 256);
                ld_data = 8'((c * 91 + 5) % 256);
            end
        end
        ld_we   = 1'b0;
        out_rdy = 1'b1;
        chk(got == n, "R6 byte count", got, n);
        ks_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int lc;
        chk(!ks_valid, "R1 valid after reset", int'(ks_valid), 0);
        model_identity();
        run_stream(4, 0, "R1 identity stream", lc);
    endtask

    task automatic t_vector();
        int lc;
        logic [7:0] ref_z [10];
        ref_z = '{8'hEB, 8'h9F, 8'h77, 8'h81, 8'hB7, 8'h34, 8'hCA, 8'h72, 8'hA7, 8'h19};
        model_ksa(8'h4B, 8'h65, 8'h79, 3);
        load_table();
        run_stream(10, 0, "R2 R4 loaded stream", lc);
        for (int k = 0; k < 10; k++)
            chk(cap[k] == ref_z[k], "R3 known vector", int'(cap[k]), int'(ref_z[k]));
        chk(lc == 11, "R6 n+1 clocks", lc, 11);
    endtask

    task automatic t_coincide();
        int lc;
        model_identity();
        model_swap(1, 2);
        model_swap(2, 255);
        load_table();
        run_stream(1, 0, "R5 t equals i", lc);
        chk(cap[0] == 8'd255, "R5 post-swap at i", int'(cap[0]), 255);
        model_identity();
        model_swap(1, 2);
        model_swap(2, 0);
        load_table();
        run_stream(1, 0, "R5 t equals j", lc);
        chk(cap[0] == 8'd2, "R5 post-swap at j", int'(cap[0]), 2);
    endtask

    task automatic t_wrap();
        int lc;
        model_ksa(8'h13, 8'hC7, 8'h5A, 3);
        load_table();
        run_stream(300, 0, "R7 wrap stream", lc);
        chk(lc == 301, "R7 R6 timing across wrap", lc, 301);
    endtask

    task automatic t_stall();
        int lc;
        run_stream(40, 1, "R8 stalled stream", lc);
    endtask

    task automatic t_zero();
        int lc;
        run_stream(0, 0, "R9 zero count", lc);
        chk(lc == -1, "R9 no strobe", lc, -1);
    endtask

    task automatic t_ignore();
        int lc;
        run_stream(30, 2, "R10 loads ignored", lc);
        run_stream(8, 0, "R10 table intact", lc);
    endtask

    task automatic t_restart();
        int lc;
        @(negedge clk);
        ks_len  = CW'(50);
        ks_en   = 1'b1;
        repeat (3) @(negedge clk);
        ks_en = 1'b0;
        // two steps ran before the abort; mirror them in the model
        mi = 0;
        mj = 0;
        void'(model_next());
        void'(model_next());
        repeat (3) @(negedge clk);
        chk(!ks_valid, "R11 idle after abort", int'(ks_valid), 0);
        run_stream(6, 0, "R11 restart stream", lc);
    endtask

    initial begin
        #(4.0 * 200000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        ld_we   = 1'b0;
        ld_addr = '0;
        ld_data = '0;
        ks_en   = 1'b0;
        ks_len  = '0;
        out_rdy = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vector();
        t_coincide();
        t_wrap();
        t_stall();
        t_zero();
        t_ignore();
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule